// File: doc/BRIEF.md
# Privilege and Illegal-Instruction Trap Entry

This block sits after instruction decode and judges each decoded instruction against the live machine state word. It takes flags that describe the instruction's class. The privileged class covers the stop/attention instruction, both directions of the state-word move, and the return-from-trap instruction. A move to or from a special register joins that class only when bit 20 of its instruction word is set. The block also takes the current instruction address and the current state word. From these it decides one of three outcomes: take a program trap, stop the machine, or let the instruction run.

On a trap the block captures three things on a single clock edge: the faulting address in a save-address register, a copy of the old state word in a save-state register, and a rewritten state word. The save-state copy carries a cause bit that tells a privilege fault from an illegal instruction. The cause bit goes only into the saved copy, never into the live state word. The block then pulses a redirect with the fixed trap vector. When the attention instruction is allowed to run, it sets a sticky halted flag.

Instructions arrive on a valid/ready interface. `in_ready` is high whenever the block is not halted. An instruction counts as accepted on a rising clock edge where both `in_valid` and `in_ready` are high. Once halted, `in_ready` stays low until reset, so the block back-pressures the upstream stage and accepts no further instruction. The outputs are registered and appear in the cycle after acceptance.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, `halted` is 0, `in_ready` is 1, `state_we` and `redirect_valid` are 0, and `save_pc`, `save_state` and `state_next` are 0.
- R2: An accepted instruction is privileged when `op_priv`, `op_attn`, or (`op_spr_move` and `spr_hi_bit`) is set. If the problem-state bit is set at the same time, a trap is taken. The problem-state bit is MSB0 bit 49 of `state_in`, which is mask 64'h4000. A trap shows in the next cycle as a one-cycle pulse on `state_we` and on `redirect_valid`, with `redirect_pc` = 64'h700.
- R3: A special-register move with `spr_hi_bit` = 0 is not privileged. In problem state, with no other flag set, it produces no pulse and leaves the saved registers unchanged.
- R4: On a privilege trap, `save_pc` receives `cur_pc`. `save_state` receives the old `state_in` with the privilege cause bit set: MSB0 bit 45, which is mask 64'h4_0000.
- R5: An accepted instruction with `op_illegal` set and no privilege trap traps to 64'h700. In this case `save_state` carries the illegal cause bit, MSB0 bit 44, which is mask 64'h8_0000, instead of the privilege cause bit.
- R6: On any trap, `state_next` = (`state_in` & ~64'h0400_0001_0280_EF36) | 64'h8000_0000_0000_0001. No cause bit appears in `state_next` unless it was already set in `state_in` and survives the clear mask.
- R7: An accepted attention instruction with the problem-state bit clear sets `halted` in the next cycle. It produces no trap pulse, even when `op_illegal` is also set.
- R8: `halted` is sticky until reset. While it is set, `in_ready` is 0 and no instruction is accepted: no pulse, and the saved registers hold.
- R9: Priority order is privilege trap, then halt, then illegal trap. A privileged instruction in problem state that also has `op_attn` or `op_illegal` set takes the privilege trap and does not halt.
- R10: An accepted instruction that raises neither a trap nor a halt produces no pulse and leaves `save_pc`, `save_state`, `state_next` and `halted` unchanged.
- R11: When `in_valid` is 0, no flag on the other inputs has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Block can accept an instruction (low while halted) |
| op_priv | input | 1 | Instruction is a state-word move or return-from-trap |
| op_attn | input | 1 | Instruction is the attention/stop instruction |
| op_spr_move | input | 1 | Instruction moves to or from a special register |
| spr_hi_bit | input | 1 | Bit 20 of the instruction word |
| op_illegal | input | 1 | Decoder found no legal instruction |
| cur_pc | input | 64 | Address of the current instruction |
| state_in | input | 64 | Live machine state word |
| state_we | output | 1 | One-cycle pulse: load `state_next` into the live state |
| state_next | output | 64 | Rewritten state word after trap entry |
| save_pc | output | 64 | Saved faulting address |
| save_state | output | 64 | Saved old state word with cause bit |
| redirect_valid | output | 1 | One-cycle pulse: fetch from `redirect_pc` |
| redirect_pc | output | 64 | Trap vector address |
| halted | output | 1 | Sticky halted flag |

## Verification
Three decisions can collide on one instruction: the privilege trap, the halt, and the illegal trap. The bench raises privileged, attention and illegal flags together, both in problem state and in supervisor state. It then judges the outcome by which pulse appears, which cause bit lands in `save_state`, and whether `halted` rises. A second collision comes from a trapping instruction offered while `halted` is set. The bench checks that the block does not accept it and that the saved registers stay as they were.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    ACT_NONE      = 2'd0,
    ACT_HALT      = 2'd1,
    ACT_TRAP_PRIV = 2'd2,
    ACT_TRAP_ILL  = 2'd3
  } trap_act_e;
endpackage

// File: rtl/trap_decide.sv
module trap_decide
  import trap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      op_priv,
  input  logic      op_attn,
  input  logic      op_spr_move,
  input  logic      spr_hi_bit,
  input  logic      op_illegal,
  input  logic      prob_state,
  output trap_act_e act
);
  logic priv_class;
  logic take_priv;
  logic take_halt;
  logic take_ill;

  // privileged class: attention, state moves, return, high special moves
  assign priv_class = op_priv | op_attn | (op_spr_move & spr_hi_bit);
  assign take_priv  = priv_class & prob_state;
  assign take_halt  = !take_priv && op_attn;
  assign take_ill   = !take_priv && !op_attn && op_illegal;

  always_comb begin
    act = ACT_NONE;
    if (take_priv)      act = ACT_TRAP_PRIV;
    else if (take_halt) act = ACT_HALT;
    else if (take_ill)  act = ACT_TRAP_ILL;
  end

  // R9: at most one outcome picked
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_priv, take_halt, take_ill}));
endmodule

// File: rtl/trap_rewrite.sv
module trap_rewrite
  import trap_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter logic [63:0] CLEAR_MASK = 64'h0400_0001_0280_EF36,
  parameter logic [63:0] SET_MASK   = 64'h8000_0000_0000_0001,
  parameter int          PRIV_IDX   = 18,
  parameter int          ILL_IDX    = 19
) (
  input  trap_act_e       act,
  input  logic [XLEN-1:0] old_state,
  output logic [XLEN-1:0] new_state,
  output logic [XLEN-1:0] saved_state
);
  logic [XLEN-1:0] cause_vec;

  // per-bit rewrite of the live state; constant masks pick the variant
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (SET_MASK[b]) begin : g_set
      assign new_state[b] = 1'b1;
    end else if (CLEAR_MASK[b]) begin : g_clr
      assign new_state[b] = 1'b0;
    end else begin : g_keep
      assign new_state[b] = old_state[b];
    end
    if (b == PRIV_IDX) begin : g_cp
      assign cause_vec[b] = (act == ACT_TRAP_PRIV);
    end else if (b == ILL_IDX) begin : g_ci
      assign cause_vec[b] = (act == ACT_TRAP_ILL);
    end else begin : g_c0
      assign cause_vec[b] = 1'b0;
    end
  end

  assign saved_state = old_state | cause_vec;
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int          XLEN           = 64,
  parameter logic [63:0] TRAP_VECTOR    = 64'h700,
  parameter logic [63:0] CLEAR_MASK     = 64'h0400_0001_0280_EF36,
  parameter logic [63:0] SET_MASK       = 64'h8000_0000_0000_0001,
  parameter int          PROB_POS       = 49,
  parameter int          PRIV_CAUSE_POS = 45,
  parameter int          ILL_CAUSE_POS  = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            op_priv,
  input  logic            op_attn,
  input  logic            op_spr_move,
  input  logic            spr_hi_bit,
  input  logic            op_illegal,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] state_in,
  output logic            state_we,
  output logic [XLEN-1:0] state_next,
  output logic [XLEN-1:0] save_pc,
  output logic [XLEN-1:0] save_state,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            halted
);
  // MSB0 positions converted to vector indices
  localparam int PROB_IDX = XLEN - 1 - PROB_POS;
  localparam int PRIV_IDX = XLEN - 1 - PRIV_CAUSE_POS;
  localparam int ILL_IDX  = XLEN - 1 - ILL_CAUSE_POS;

  trap_act_e       act;
  logic [XLEN-1:0] new_state_c;
  logic [XLEN-1:0] saved_state_c;
  logic            accept;
  logic            do_trap;

  trap_decide u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_priv    (op_priv),
    .op_attn    (op_attn),
    .op_spr_move(op_spr_move),
    .spr_hi_bit (spr_hi_bit),
    .op_illegal (op_illegal),
    .prob_state (state_in[PROB_IDX]),
    .act        (act)
  );

  trap_rewrite #(
    .XLEN      (XLEN),
    .CLEAR_MASK(CLEAR_MASK),
    .SET_MASK  (SET_MASK),
    .PRIV_IDX  (PRIV_IDX),
    .ILL_IDX   (ILL_IDX)
  ) u_rewrite (
    .act        (act),
    .old_state  (state_in),
    .new_state  (new_state_c),
    .saved_state(saved_state_c)
  );

  assign in_ready    = !halted;
  assign accept      = in_valid && in_ready;
  assign do_trap     = accept && (act == ACT_TRAP_PRIV || act == ACT_TRAP_ILL);
  assign redirect_pc = TRAP_VECTOR[XLEN-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_we       <= 1'b0;
      redirect_valid <= 1'b0;
      state_next     <= '0;
      save_pc        <= '0;
      save_state     <= '0;
      halted         <= 1'b0;
    end else begin
      state_we       <= do_trap;
      redirect_valid <= do_trap;
      if (do_trap) begin
        state_next <= new_state_c;
        save_pc    <= cur_pc;
        save_state <= saved_state_c;
      end
      if (accept && act == ACT_HALT) halted <= 1'b1;
    end
  end

  // R8: halted never drops without reset
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R8: back-pressure while halted
  p_no_ready_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !in_ready);
  // R11: no pulse without a valid instruction
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !state_we && !redirect_valid);
  // R4: faulting address is captured on trap
  p_save_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_trap |=> save_pc == $past(cur_pc));
  // R6: forced-one bits present in every rewritten state
  p_set_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |-> (state_next & SET_MASK[XLEN-1:0]) == SET_MASK[XLEN-1:0]);
  // R7: a halt step never redirects
  p_halt_no_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> !redirect_valid);
endmodule

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;
  localparam logic [63:0] CLR  = 64'h0400_0001_0280_EF36;
  localparam logic [63:0] SETM = 64'h8000_0000_0000_0001;
  localparam logic [63:0] PROB = 64'h4000;
  localparam logic [63:0] CPRV = 64'h4_0000;
  localparam logic [63:0] CILL = 64'h8_0000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic op_priv = 0, op_attn = 0, op_spr_move = 0, spr_hi_bit = 0, op_illegal = 0;
  logic [63:0] cur_pc = 0, state_in = 0;
  logic state_we, redirect_valid, halted;
  logic [63:0] state_next, save_pc, save_state, redirect_pc;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  trap_entry_unit i_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_priv(op_priv), .op_attn(op_attn), .op_spr_move(op_spr_move),
    .spr_hi_bit(spr_hi_bit), .op_illegal(op_illegal), .cur_pc(cur_pc),
    .state_in(state_in), .state_we(state_we), .state_next(state_next),
    .save_pc(save_pc), .save_state(save_state),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .halted(halted)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rewrite(input logic [63:0] s);
    return (s & ~CLR) | SETM;
  endfunction

  // drive one instruction for a cycle, return at the next negedge
  task automatic issue(input logic v, input logic p, input logic a, input logic sm,
                       input logic hb, input logic il, input logic [63:0] pc,
                       input logic [63:0] st);
    in_valid = v; op_priv = p; op_attn = a; op_spr_move = sm; spr_hi_bit = hb;
    op_illegal = il; cur_pc = pc; state_in = st;
    @(negedge clk);
    in_valid = 0; op_priv = 0; op_attn = 0; op_spr_move = 0; spr_hi_bit = 0;
    op_illegal = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 halted", halted, 0);
    chk("R1 ready", in_ready, 1);
    chk("R1 pulses", {state_we, redirect_valid}, 0);
    chk("R1 save_pc", save_pc, 0);
    chk("R1 save_state", save_state, 0);
    chk("R1 state_next", state_next, 0);
  endtask

  task automatic t_priv_trap();
    logic [63:0] st = 64'h1234_5678_9ABC_8EF0 | PROB;
    issue(1, 1, 0, 0, 0, 0, 64'h1000, st);
    chk("R2 redirect", redirect_valid, 1);
    chk("R2 we", state_we, 1);
    chk("R2 vector", redirect_pc, 64'h700);
    chk("R4 save_pc", save_pc, 64'h1000);
    chk("R4 save_state", save_state, st | CPRV);
    chk("R6 state_next", state_next, rewrite(st));
    @(negedge clk);
    chk("R2 pulse one cycle", {state_we, redirect_valid}, 0);
    // high special move traps too
    issue(1, 0, 0, 1, 1, 0, 64'h2000, PROB);
    chk("R2 spr hi trap", redirect_valid, 1);
    chk("R4 spr hi save_pc", save_pc, 64'h2000);
  endtask

  task automatic t_spr_low();
    logic [63:0] sp = save_pc, ss = save_state;
    issue(1, 0, 0, 1, 0, 0, 64'h3000, PROB);
    chk("R3 no pulse", {state_we, redirect_valid}, 0);
    chk("R3 save_pc hold", save_pc, sp);
    chk("R3 save_state hold", save_state, ss);
  endtask

  task automatic t_illegal();
    logic [63:0] st = 64'hFFFF_FFFF_FFF3_FFFF; // cause bits clear, rest ones
    issue(1, 0, 0, 0, 0, 1, 64'h4444, st);
    chk("R5 redirect", redirect_valid, 1);
    chk("R5 save_state", save_state, st | CILL);
    chk("R6 ill state_next", state_next, rewrite(st));
    chk("R6 no cause in live", state_next & (CPRV | CILL), 0);
  endtask

  task automatic t_priority();
    issue(1, 1, 1, 0, 0, 1, 64'h5550, PROB | 64'h1);
    chk("R9 priv wins", redirect_valid, 1);
    chk("R9 priv cause", save_state & (CPRV | CILL), CPRV);
    chk("R9 no halt", halted, 0);
  endtask

  task automatic t_idle_none();
    logic [63:0] sp = save_pc, ss = save_state, sn = state_next;
    issue(0, 1, 1, 1, 1, 1, 64'h9999, PROB);
    chk("R11 no pulse", {state_we, redirect_valid}, 0);
    chk("R11 no halt", halted, 0);
    chk("R11 save_pc hold", save_pc, sp);
    issue(1, 0, 0, 0, 0, 0, 64'h7777, 64'hABCD);
    chk("R10 no pulse", {state_we, redirect_valid}, 0);
    chk("R10 hold", {save_pc ^ sp, save_state ^ ss, state_next ^ sn}, 0);
    chk("R10 no halt", halted, 0);
  endtask

  task automatic t_halt();
    logic [63:0] sp = save_pc, ss = save_state;
    issue(1, 0, 1, 0, 0, 1, 64'h8888, 64'h0);
    chk("R7 halted", halted, 1);
    chk("R7 no trap", {state_we, redirect_valid}, 0);
    chk("R7 save hold", save_pc, sp);
    chk("R8 not ready", in_ready, 0);
    issue(1, 1, 0, 0, 0, 1, 64'hAAAA, PROB);
    chk("R8 blocked", {state_we, redirect_valid}, 0);
    chk("R8 save_pc hold", save_pc, sp);
    chk("R8 save_state hold", save_state, ss);
    repeat (3) @(negedge clk);
    chk("R8 sticky", halted, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_priv_trap();
    t_spr_low();
    t_illegal();
    t_priority();
    t_idle_none();
    t_halt();
    do_reset();
    chk("R1 reset clears halt", halted, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule